// File: doc/BRIEF.md
# Reference-Fault Result Guard

This block sits between a converter core and the registers that software reads. It watches a flag from an external comparator. The flag is high whenever the converter's reference is unusable, meaning the differential reference is below its threshold or one of the reference pins is open. The block brings this flag into the clock domain through a flop chain and reports it on a status output.

While the reference is bad, every finished conversion is written into the data register as an all-ones word instead of the core's result. Every finished offset or gain calibration leaves its coefficient register unchanged. With this behaviour a host can read results without polling status. It only needs to look at the status bit after it reads an all-ones word, and after a calibration it can check the bit to confirm that the new coefficients were accepted.

Each completion strobe is judged against the synchronized fault level in the same clock cycle. A result is therefore either stored whole or replaced whole. While the reference is good, all three registers load exactly as the core delivers their values.

Top module: `refguard_top`

## Requirements
- R1: While reset is high and on the first clock after it, the data register reads 0, the offset register reads 0, the gain register reads midscale (only the most significant bit set, 0x800000 at 24 bits) and the status output reads 0.
- R2: The status output equals the raw no-reference input as sampled two rising clock edges earlier, both when it rises and when it falls. It is not sticky.
- R3: A conversion strobe sampled while the status output is 0 loads the converter result into the data register on that edge.
- R4: A conversion strobe sampled while the status output is 1 loads all ones (0xFFFFFF at 24 bits) into the data register on that edge.
- R5: An offset calibration strobe loads the offset coefficient when the status output is 0 and leaves the offset register unchanged when it is 1.
- R6: A gain calibration strobe loads the gain coefficient when the status output is 0 and leaves the gain register unchanged when it is 1.
- R7: On a cycle without its strobe, each register keeps its value, whatever its data input does.
- R8: The three strobes act independently. Any combination asserted in one cycle updates each register by its own rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| no_ref_raw_i | input | 1 | Asynchronous reference-fault flag from the comparator |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_result_i | input | 24 | Conversion result from the core |
| ofs_done_i | input | 1 | Offset calibration finished strobe |
| ofs_coef_i | input | 24 | New offset coefficient |
| gain_done_i | input | 1 | Gain calibration finished strobe |
| gain_coef_i | input | 24 | New gain coefficient |
| data_o | output | 24 | Data register |
| ofs_o | output | 24 | Offset calibration register |
| gain_o | output | 24 | Gain calibration register |
| no_ref_o | output | 1 | Synchronized reference-fault status |

## Verification
The random phase holds the fault flag in long runs and toggles it rarely, and it drives the strobes with random data. This exercises each gating rule under both fault levels and across the edges where the flag changes.

Directed cases cover four points:
- A genuine all-ones conversion taken with the reference good. Here the status bit is the only way to tell it from a substituted word.
- Strobes issued in the two cycles just after the raw flag moves. These show that the synchronized level decides, not the raw one.
- All three strobes in a single cycle.
- Changes on the data inputs without any strobe, which must leave the registers unchanged.

// File: rtl/refg_pkg.sv
package refg_pkg;
  localparam int unsigned WORD_W_DEF = 24;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_LOAD   = 2'd1,
    UPD_FORCE  = 2'd2,
    UPD_BLOCK  = 2'd3
  } upd_kind_e;

  // Decide what a register does this cycle from its strobe and the fault level.
  function automatic upd_kind_e decide(input logic strobe, input logic fault,
                                       input logic substitute);
    if (!strobe)          return UPD_HOLD;
    else if (!fault)      return UPD_LOAD;
    else if (substitute)  return UPD_FORCE;
    else                  return UPD_BLOCK;
  endfunction
endpackage

// File: rtl/refg_sync.sv
module refg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic flag_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign flag_o = chain_q[STAGES-1];

  // Age counter used only to arm the latency check after reset.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (flag_o == $past(raw_i, 2))) else $error("sync latency"); // R2
    end
  endgenerate
endmodule

// File: rtl/refg_result_reg.sv
module refg_result_reg
  import refg_pkg::*;
#(
  parameter int unsigned W = WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fault_i,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  output logic [W-1:0] data_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  upd_kind_e kind;
  assign kind = decide(done_i, fault_i, 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
    end else begin
      unique case (kind)
        UPD_LOAD:  data_o <= result_i;
        UPD_FORCE: data_o <= ALL_ONES;
        default:   data_o <= data_o;
      endcase
    end
  end

  AST_RES_LOAD: assert property (@(posedge clk) disable iff (rst)
    (done_i && !fault_i) |=> (data_o == $past(result_i))) else $error("load"); // R3
  AST_RES_FORCE: assert property (@(posedge clk) disable iff (rst)
    (done_i && fault_i) |=> (data_o == ALL_ONES)) else $error("force"); // R4
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done_i) |=> $stable(data_o)) else $error("hold"); // R7
endmodule

// File: rtl/refg_cal_reg.sv
module refg_cal_reg
  import refg_pkg::*;
#(
  parameter int unsigned   W         = WORD_W_DEF,
  parameter logic [W-1:0]  RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fault_i,
  input  logic         done_i,
  input  logic [W-1:0] coef_i,
  output logic [W-1:0] coef_o
);
  upd_kind_e kind;
  assign kind = decide(done_i, fault_i, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_o <= RESET_VAL;
    end else if (kind == UPD_LOAD) begin
      coef_o <= coef_i;
    end
  end

  AST_CAL_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (done_i && fault_i) |=> $stable(coef_o)) else $error("inhibit"); // R5 R6
  AST_CAL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (done_i && !fault_i) |=> (coef_o == $past(coef_i))) else $error("cal load"); // R5 R6
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done_i) |=> $stable(coef_o)) else $error("cal hold"); // R7
endmodule

// File: rtl/refguard_top.sv
module refguard_top
  import refg_pkg::*;
#(
  parameter int unsigned W      = WORD_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         no_ref_raw_i,
  input  logic         conv_done_i,
  input  logic [W-1:0] conv_result_i,
  input  logic         ofs_done_i,
  input  logic [W-1:0] ofs_coef_i,
  input  logic         gain_done_i,
  input  logic [W-1:0] gain_coef_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] ofs_o,
  output logic [W-1:0] gain_o,
  output logic         no_ref_o
);
  localparam logic [W-1:0] GAIN_MID = {1'b1, {(W-1){1'b0}}};

  logic fault;

  refg_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst(rst), .raw_i(no_ref_raw_i), .flag_o(fault)
  );

  assign no_ref_o = fault;

  refg_result_reg #(.W(W)) res_i (
    .clk(clk), .rst(rst), .fault_i(fault), .done_i(conv_done_i),
    .result_i(conv_result_i), .data_o(data_o)
  );

  refg_cal_reg #(.W(W), .RESET_VAL('0)) ofs_i (
    .clk(clk), .rst(rst), .fault_i(fault), .done_i(ofs_done_i),
    .coef_i(ofs_coef_i), .coef_o(ofs_o)
  );

  refg_cal_reg #(.W(W), .RESET_VAL(GAIN_MID)) gain_i (
    .clk(clk), .rst(rst), .fault_i(fault), .done_i(gain_done_i),
    .coef_i(gain_coef_i), .coef_o(gain_o)
  );

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (data_o == '0 && ofs_o == '0 && gain_o == GAIN_MID && !no_ref_o))
    else $error("reset"); // R1
  AST_STRB_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
    (conv_done_i && !ofs_done_i && !gain_done_i) |=> ($stable(ofs_o) && $stable(gain_o)))
    else $error("independent"); // R8
endmodule

// File: tb/refguard_top_tb_top.sv
module refguard_top_tb_top;
  localparam int W = 24;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0, cd = 1'b0, od = 1'b0, gd = 1'b0;
  logic [W-1:0] cr = '0, oc = '0, gc = '0;
  logic [W-1:0] data_o, ofs_o, gain_o;
  logic no_ref_o;

  int vecs = 0, errs = 0;
  logic m_s1 = 1'b0, m_s2 = 1'b0;
  logic [W-1:0] m_data = '0, m_ofs = '0, m_gain = MID;

  always #4 clk = ~clk;

  refguard_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .no_ref_raw_i(raw),
    .conv_done_i(cd), .conv_result_i(cr),
    .ofs_done_i(od), .ofs_coef_i(oc),
    .gain_done_i(gd), .gain_coef_i(gc),
    .data_o(data_o), .ofs_o(ofs_o), .gain_o(gain_o), .no_ref_o(no_ref_o)
  );

  function automatic logic [W-1:0] exp_data(logic [W-1:0] old, logic d, logic f, logic [W-1:0] r);
    if (!d) return old;
    return f ? ONES : r;
  endfunction

  function automatic logic [W-1:0] exp_cal(logic [W-1:0] old, logic d, logic f, logic [W-1:0] c);
    return (d && !f) ? c : old;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: inputs are already driven; model the edge, then compare at negedge.
  task automatic step();
    logic f;
    f = m_s2;
    @(posedge clk);
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_data = '0; m_ofs = '0; m_gain = MID;
    end else begin
      m_data = exp_data(m_data, cd, f, cr);
      m_ofs  = exp_cal(m_ofs, od, f, oc);
      m_gain = exp_cal(m_gain, gd, f, gc);
      m_s2 = m_s1; m_s1 = raw;
    end
    @(negedge clk);
    chk("R2 status", {{(W-1){1'b0}}, no_ref_o}, {{(W-1){1'b0}}, m_s2});
    chk(f ? "R4 R7 data" : "R3 R7 data", data_o, m_data);
    chk("R5 R8 offset", ofs_o, m_ofs);
    chk("R6 R8 gain", gain_o, m_gain);
  endtask

  task automatic drive(logic r, logic c, logic o, logic g,
                       logic [W-1:0] rv, logic [W-1:0] ov, logic [W-1:0] gv);
    raw = r; cd = c; od = o; gd = g; cr = rv; oc = ov; gc = gv;
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk);
    drive(1, 1, 1, 1, 24'h123456, 24'h654321, 24'h0F0F0F);
    step(); step();
    // R1 reset values
    chk("R1 data", data_o, '0);
    chk("R1 offset", ofs_o, '0);
    chk("R1 gain", gain_o, MID);
    chk("R1 status", {{(W-1){1'b0}}, no_ref_o}, '0);
    rst = 0;
    drive(0, 0, 0, 0, '0, '0, '0);
    step();
    chk("R1 gain after reset", gain_o, MID);

    // R3 valid loads, including a genuine all-ones result
    drive(0, 1, 1, 1, 24'hABCDEF, 24'h000123, 24'h7FFFFE); step();
    chk("R8 all three", gain_o, 24'h7FFFFE);
    drive(0, 1, 0, 0, ONES, '0, '0); step();
    chk("R3 real ones", data_o, ONES);
    chk("R3 status low", {{(W-1){1'b0}}, no_ref_o}, '0);

    // R7 data change without strobes
    drive(0, 0, 0, 0, 24'h111111, 24'h222222, 24'h333333); step(); step();

    // R2 raw rises: strobes in the two following cycles still see valid
    drive(1, 1, 1, 1, 24'h000010, 24'h000020, 24'h000030); step();
    chk("R2 not yet", {{(W-1){1'b0}}, no_ref_o}, '0);
    drive(1, 1, 1, 1, 24'h000011, 24'h000021, 24'h000031); step();
    chk("R2 risen", {{(W-1){1'b0}}, no_ref_o}, 24'h1);
    chk("R3 last valid", data_o, 24'h000011);
    drive(1, 1, 1, 1, 24'h000012, 24'h000022, 24'h000032); step();
    chk("R4 substituted", data_o, ONES);
    chk("R5 blocked", ofs_o, 24'h000021);
    chk("R6 blocked", gain_o, 24'h000031);

    // R2 raw falls: not sticky
    drive(0, 0, 0, 0, '0, '0, '0); step(); step();
    chk("R2 fell", {{(W-1){1'b0}}, no_ref_o}, '0);

    // random phase with runs of fault
    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = raw;
      if ($urandom_range(0, 15) == 0) r = ~raw;
      drive(r, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 3) == 0, W'($urandom), W'($urandom), W'($urandom));
      step();
    end

    // mid-run reset returns values (R1)
    rst = 1; step(); rst = 0;
    chk("R1 rereset gain", gain_o, MID);
    drive(0, 0, 0, 0, '0, '0, '0); step();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule